// File: doc/BRIEF.md
# Segment Address Translator

This block turns a 32-bit virtual address into a physical address by searching a small table of segment descriptors. Each descriptor names a window of virtual space by its starting virtual address and its length, and gives the physical address where that window begins. A descriptor also carries an enable bit. A supervisor fills the table through a one-word-at-a-time configuration write port.

A requester presents a virtual address with a strobe. One clock later the block returns one of two results, marked by a single-cycle valid pulse. The first is the translated physical address. The second is an illegal-address fault that carries the virtual address that failed. All enabled descriptors are compared in parallel, and the lowest-numbered one that matches wins. If only descriptor 0 is programmed, the block behaves as a plain base-and-bounds unit.

The control is a two-state machine: `ST_IDLE` (no result pending) and `ST_RESP` (a result is being presented). The transitions are:
- `IDLE->RESP` on a strobe.
- `RESP->RESP` on a back-to-back strobe.
- `RESP->IDLE` when no strobe arrives.

Top module: `seg_xlate`

## Requirements
- R1: After reset every descriptor is disabled with all fields zero, and `rsp_valid` is low, so any request made before programming faults.
- R2: A write with `cfg_we` high stores `cfg_wdata` into descriptor `cfg_idx`. The field is chosen by `cfg_sel`: 0 = virtual base, 1 = physical base, 2 = length, 3 = enable (taken from `cfg_wdata[0]`).
- R3: A descriptor matches only when the virtual address is not below its virtual base (detected as an unsigned borrow) and the offset (address minus virtual base) is strictly less than its length. The address equal to the base matches, base+length-1 matches, base+length does not, and base-1 does not.
- R4: On a match, `rsp_paddr` equals the matching descriptor's physical base plus the offset, modulo 2^32.
- R5: When several descriptors match, the one with the lowest index supplies the translation.
- R6: A disabled descriptor never matches, whatever its fields hold.
- R7: When no descriptor matches, `rsp_fault` is high, `rsp_fault_addr` equals the requested virtual address, and `rsp_paddr` is zero. On a successful translation `rsp_fault` and `rsp_fault_addr` are zero.
- R8: `rsp_valid` pulses for exactly the cycle after each strobe, including on back-to-back strobes. `rsp_fault` is never high without `rsp_valid`.
- R9: A descriptor write in the same cycle as a strobe does not affect that request's result. It applies from the next request onward.
- R10: A descriptor with length zero never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_idx | input | 3 | Descriptor index to write |
| cfg_sel | input | 2 | Field select: 0 virtual base, 1 physical base, 2 length, 3 enable |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Translation strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_fault | output | 1 | Illegal-address fault |
| rsp_paddr | output | 32 | Translated physical address (zero on fault) |
| rsp_fault_addr | output | 32 | Faulting virtual address (zero on success) |

## Verification
The hardest situation to reach from the ports is several enabled descriptors overlapping the same address, with the request landing exactly on a window edge. Uniform random addresses almost never hit such an edge. The random phase therefore places every virtual base inside a narrow shared region with short lengths, so windows overlap often. It draws request addresses from that region, biased toward each base, base-1, and base+length. Directed cases add a descriptor write in the same cycle as a strobe, a zero length, and a window that wraps the physical address.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    parameter int ADDR_W = 32;
    parameter int N_SEG  = 8;
    localparam int IDX_W = $clog2(N_SEG);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] vbase;
        logic [ADDR_W-1:0] pbase;
        logic [ADDR_W-1:0] len;
    } seg_desc_t;

    typedef enum logic [1:0] {
        SEL_VBASE = 2'd0,
        SEL_PBASE = 2'd1,
        SEL_LEN   = 2'd2,
        SEL_EN    = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xl_state_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [1:0]          wr_sel,
    input  logic [ADDR_W-1:0]   wr_data,
    output seg_desc_t           desc [N_SEG]
);
    for (genvar g = 0; g < N_SEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                unique case (cfg_sel_e'(wr_sel))
                    SEL_VBASE: desc[g].vbase <= wr_data;
                    SEL_PBASE: desc[g].pbase <= wr_data;
                    SEL_LEN:   desc[g].len   <= wr_data;
                    SEL_EN:    desc[g].en    <= wr_data[0];
                endcase
            end
        end
    end
endmodule

// File: rtl/seg_range_match.sv
module seg_range_match
    import seg_xlate_pkg::*;
(
    input  seg_desc_t           desc [N_SEG],
    input  logic [ADDR_W-1:0]   vaddr,
    output logic [N_SEG-1:0]    hit,
    output logic [ADDR_W-1:0]   paddr [N_SEG]
);
    for (genvar g = 0; g < N_SEG; g++) begin : g_cmp
        logic [ADDR_W:0]   diff;
        logic              borrow;
        logic [ADDR_W-1:0] offset;
        always_comb begin
            diff     = {1'b0, vaddr} - {1'b0, desc[g].vbase};
            borrow   = diff[ADDR_W];
            offset   = diff[ADDR_W-1:0];
            hit[g]   = desc[g].en && !borrow && (offset < desc[g].len);
            paddr[g] = desc[g].pbase + offset;
        end
    end
endmodule

// File: rtl/seg_prio_pick.sv
module seg_prio_pick
    import seg_xlate_pkg::*;
(
    input  logic [N_SEG-1:0]    hit,
    input  logic [ADDR_W-1:0]   paddr [N_SEG],
    output logic                any_hit,
    output logic [ADDR_W-1:0]   sel_paddr
);
    always_comb begin
        any_hit   = 1'b0;
        sel_paddr = '0;
        for (int i = N_SEG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit   = 1'b1;
                sel_paddr = paddr[i];
            end
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [1:0]          cfg_sel,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_vaddr,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic [ADDR_W-1:0]   rsp_fault_addr
);
    seg_desc_t         desc [N_SEG];
    logic [N_SEG-1:0]  hit;
    logic [ADDR_W-1:0] cand_pa [N_SEG];
    logic              any_hit;
    logic [ADDR_W-1:0] pick_pa;
    xl_state_e         state_q, state_d;

    seg_desc_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .desc    (desc)
    );

    seg_range_match u_match (
        .desc  (desc),
        .vaddr (req_vaddr),
        .hit   (hit),
        .paddr (cand_pa)
    );

    seg_prio_pick u_pick (
        .hit       (hit),
        .paddr     (cand_pa),
        .any_hit   (any_hit),
        .sel_paddr (pick_pa)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_fault_addr <= '0;
        end else if (req_valid) begin
            rsp_fault      <= !any_hit;
            rsp_paddr      <= any_hit ? pick_pa : '0;
            rsp_fault_addr <= any_hit ? '0 : req_vaddr;
        end else begin
            rsp_fault      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_fault_addr <= '0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              rsp_valid,
    input  logic              rsp_fault,
    input  logic [ADDR_W-1:0] rsp_paddr,
    input  logic [ADDR_W-1:0] rsp_fault_addr
);
    assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_stray_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_fault_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);
    assert_fault_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_fault || rsp_fault_addr == $past(req_vaddr)));
    assert_fault_pa_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_paddr == '0);
    assert_ok_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_fault_addr == '0);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !rsp_fault);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_fault      (rsp_fault),
    .rsp_paddr      (rsp_paddr),
    .rsp_fault_addr (rsp_fault_addr)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr, rsp_fault_addr;

    int n_vec = 0;
    int n_bad = 0;

    logic        m_en [8];
    logic [31:0] m_vb [8];
    logic [31:0] m_pb [8];
    logic [31:0] m_ln [8];

    always #10 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_fault_addr(rsp_fault_addr)
    );

    function automatic logic [64:0] model(input logic [31:0] va);
        for (int i = 0; i < 8; i++) begin
            logic [32:0] d;
            d = {1'b0, va} - {1'b0, m_vb[i]};
            if (m_en[i] && !d[32] && d[31:0] < m_ln[i])
                return {1'b0, m_pb[i] + d[31:0], 32'h0};
        end
        return {1'b1, 32'h0, va};
    endfunction

    task automatic chk(input string tag, input logic [64:0] got, input logic [64:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got fault=%0b pa=%h fa=%h expected fault=%0b pa=%h fa=%h",
                     tag, got[64], got[63:32], got[31:0], exp[64], exp[63:32], exp[31:0]);
        end
    endtask

    task automatic wr(input int idx, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_vb[idx] = d;
            1: m_pb[idx] = d;
            2: m_ln[idx] = d;
            default: m_en[idx] = d[0];
        endcase
    endtask

    task automatic seg(input int idx, input logic [31:0] vb, input logic [31:0] pb,
                       input logic [31:0] ln, input logic en);
        wr(idx, 0, vb); wr(idx, 1, pb); wr(idx, 2, ln); wr(idx, 3, {31'b0, en});
    endtask

    task automatic xl(input string tag, input logic [31:0] va);
        logic [64:0] e;
        @(negedge clk);
        e = model(va);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, {rsp_fault, rsp_paddr, rsp_fault_addr}, e);
        if (rsp_valid !== 1'b1) begin
            n_bad++; $display("FAIL R8: rsp_valid=%0b expected 1", rsp_valid);
        end
        @(negedge clk);
        n_vec++;
        if (rsp_valid !== 1'b0) begin
            n_bad++; $display("FAIL R8: rsp_valid=%0b expected 0 after pulse", rsp_valid);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [64:0] e1, e2;
        int unsigned sd;
        sd = $urandom(32'h5eed_1234);
        for (int i = 0; i < 8; i++) begin
            m_en[i] = 0; m_vb[i] = 0; m_pb[i] = 0; m_ln[i] = 0;
        end
        rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_sel = 0; cfg_wdata = 0;
        req_valid = 0; req_vaddr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state quiet, everything faults
        n_vec++;
        if (rsp_valid !== 0) begin n_bad++; $display("FAIL R1: rsp_valid=%0b expected 0", rsp_valid); end
        xl("R1 unprogrammed", 32'h0000_0000);
        xl("R1 unprogrammed", 32'h1234_5678);

        // R2/R3/R4 base-and-bounds with descriptor 0
        seg(0, 32'h0000_1000, 32'h8000_0000, 32'h100, 1);
        xl("R3 at base", 32'h0000_1000);
        xl("R3 last byte", 32'h0000_10FF);
        xl("R3 one past end", 32'h0000_1100);
        xl("R3 below base borrow", 32'h0000_0FFF);
        xl("R4 mid", 32'h0000_1042);
        // R2 field independence: re-write only physical base
        wr(0, 1, 32'h0004_0000);
        xl("R2 pbase rewrite", 32'h0000_1010);

        // R5 overlap priority
        seg(3, 32'h0000_1000, 32'hA000_0000, 32'h1000, 1);
        xl("R5 lower index wins", 32'h0000_1080);
        xl("R5 only upper matches", 32'h0000_1800);
        // R6 disable lower
        wr(0, 3, 32'h0);
        xl("R6 disabled skipped", 32'h0000_1080);
        seg(1, 32'h0000_5000, 32'h1, 32'h10, 0);
        xl("R6 disabled never matches", 32'h0000_5004);
        // R10 zero length
        seg(2, 32'h0000_7000, 32'h2000, 32'h0, 1);
        xl("R10 zero length", 32'h0000_7000);
        // R4 physical wrap
        seg(4, 32'hF000_0000, 32'hFFFF_FFF0, 32'h100, 1);
        xl("R4 pa wraps", 32'hF000_0020);
        // R7 fault reports address
        xl("R7 fault addr", 32'hDEAD_BEEC);

        // R8 back-to-back strobes
        @(negedge clk);
        e1 = model(32'h0000_1800);
        req_valid = 1; req_vaddr = 32'h0000_1800;
        @(negedge clk);
        e2 = model(32'h0000_9999);
        chk("R8 b2b first", {rsp_fault, rsp_paddr, rsp_fault_addr}, e1);
        req_vaddr = 32'h0000_9999;
        @(negedge clk);
        req_valid = 0;
        chk("R8 b2b second", {rsp_fault, rsp_paddr, rsp_fault_addr}, e2);
        n_vec++;
        if (rsp_valid !== 1) begin n_bad++; $display("FAIL R8: second pulse rsp_valid=%0b expected 1", rsp_valid); end

        // R9 write collides with request: enable seg 1 in the same cycle
        @(negedge clk);
        e1 = model(32'h0000_5004);
        req_valid = 1; req_vaddr = 32'h0000_5004;
        cfg_we = 1; cfg_idx = 3'd1; cfg_sel = 2'd3; cfg_wdata = 32'h1;
        @(negedge clk);
        req_valid = 0; cfg_we = 0;
        chk("R9 same-cycle write unseen", {rsp_fault, rsp_paddr, rsp_fault_addr}, e1);
        m_en[1] = 1;
        xl("R9 write seen next", 32'h0000_5004);

        // Random phase: tightly packed overlapping windows
        for (int r = 0; r < 60; r++) begin
            for (int i = 0; i < 8; i++)
                seg(i, 32'h0002_0000 + ($urandom % 32'h200), $urandom,
                    $urandom % 32'h120, 1'($urandom % 4 != 0));
            for (int k = 0; k < 40; k++) begin
                int j;
                logic [31:0] va;
                j = $urandom % 8;
                case ($urandom % 4)
                    0: va = m_vb[j];
                    1: va = m_vb[j] - 1;
                    2: va = m_vb[j] + m_ln[j];
                    default: va = 32'h0001_FF00 + ($urandom % 32'h500);
                endcase
                xl("R3 R5 random", va);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule